// File: doc/BRIEF.md
# Peripheral Set/Clear Register Bank

This block is the software-visible register bank of a generic on-chip peripheral, reached as a zero-wait-state APB slave on a 32-bit bus. It holds a mode word and a data word that software reads and writes directly. It also has a command register that only accepts writes and turns each one-bit into a single-cycle pulse toward the peripheral's datapath.

Two state vectors are never written directly: the channel enables and the interrupt mask. Each has its own pair of write-one-to-set and write-one-to-clear offsets, plus a read-back offset. Software can therefore change any subset of bits with a single write, without a read-modify-write sequence. A read-only status offset shows the peripheral's live status lines. The interrupt request is formed by masking the status with the mask and reducing the result with OR.

Accesses are treated as whole words: the two lowest address bits are ignored.

Top module: `periph_regbank`

Offset map (byte offsets, `paddr[11:6]` must be zero for any hit):
- 0x00 command (write only)
- 0x04 mode
- 0x10 channel set
- 0x14 channel clear
- 0x18 channel read-back
- 0x20 status (read only)
- 0x24 mask set
- 0x28 mask clear
- 0x2C mask read-back
- 0x30 data

## Requirements
- R1: `paddr[1:0]` is ignored, so an access at offset N+1, N+2 or N+3 behaves exactly like an access at word offset N.
- R2: A write to 0x00 drives `cmd_o` with `pwdata[7:0]` for exactly the one clock cycle after the write's access edge; `cmd_o` is zero at all other times; a read of 0x00 returns zero.
- R3: The mode word (`pwdata[15:0]` at 0x04) is read/write, resets to 0, and is driven on `mode_o`.
- R4: A write to 0x10 sets each channel enable bit that is one in `pwdata[7:0]`, and a write to 0x14 clears each such bit. Zero bits leave the enables unchanged. The enables read back at 0x18 and drive `chan_en_o`. They reset to 0.
- R5: A write to 0x24 sets each mask bit that is one in `pwdata[7:0]`, and a write to 0x28 clears each such bit. Zero bits leave the mask unchanged. The mask reads back at 0x2C and resets to 0.
- R6: `irq_o` is high in the same cycle that any bit of `stat_i` AND mask is high, and low otherwise.
- R7: A read of 0x20 returns `stat_i` in bits [7:0]; writes to 0x20 change nothing.
- R8: The data word at 0x30 is read/write over all 32 bits, resets to 0, and is driven on `data_o`.
- R9: Bits above a register's width read as zero. Reads of write-only or unmapped offsets return zero. Writes to unmapped offsets change no state.
- R10: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer done, tied high |
| pslverr | output | 1 | Error response, tied low |
| stat_i | input | 8 | Live status lines from the peripheral |
| cmd_o | output | 8 | One-cycle command pulses |
| mode_o | output | 16 | Mode configuration |
| chan_en_o | output | 8 | Channel enables |
| data_o | output | 32 | Data word |
| irq_o | output | 1 | Interrupt request |

## Verification
The case that is hardest to reach from the ports is a set or clear write whose data mixes ones and zeros over bits that are already in both states. Only that pattern shows that zero bits really leave state alone and that one bits act only on their own position. The bench drives random data words into the set and clear offsets after earlier random writes have left partial patterns, and it compares each read-back with a model. The command pulse lasts a single cycle, so it is sampled in the cycle after the access edge and again one cycle later. The bench also issues accesses with random low address bits, and with upper address bits set, to exercise the word aliasing and the unmapped space.

// File: rtl/periph_regbank_pkg.sv
// Shared word indices, write strobes and read selects for the register bank.
package periph_regbank_pkg;
    localparam int unsigned BUS_W = 32;

    localparam logic [3:0] IDX_CTRL   = 4'd0;
    localparam logic [3:0] IDX_MODE   = 4'd1;
    localparam logic [3:0] IDX_EN     = 4'd4;
    localparam logic [3:0] IDX_DIS    = 4'd5;
    localparam logic [3:0] IDX_ENSTAT = 4'd6;
    localparam logic [3:0] IDX_STAT   = 4'd8;
    localparam logic [3:0] IDX_IE     = 4'd9;
    localparam logic [3:0] IDX_ID     = 4'd10;
    localparam logic [3:0] IDX_MASK   = 4'd11;
    localparam logic [3:0] IDX_DATA   = 4'd12;

    typedef struct packed {
        logic ctrl;
        logic mode;
        logic en;
        logic dis;
        logic ie;
        logic id;
        logic data;
    } wr_strobe_t;

    typedef enum logic [2:0] {
        RD_ZERO,
        RD_MODE,
        RD_ENSTAT,
        RD_STAT,
        RD_MASK,
        RD_DATA
    } rd_sel_t;
endpackage

// File: rtl/periph_apb_decode.sv
// Address decoder: turns an APB access into one write strobe and a read select.
// Assumes word accesses only; paddr[1:0] is ignored and any set bit above
// bit 5 makes the access unmapped.
module periph_apb_decode
    import periph_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output wr_strobe_t        wr,
    output rd_sel_t           rd_sel
);
    localparam int unsigned HI_W = ADDR_W - 6;

    logic       hit;
    logic [3:0] idx;
    logic       wr_acc;

    assign hit    = (paddr[ADDR_W-1:6] == HI_W'(0));
    assign idx    = paddr[5:2];
    assign wr_acc = psel && penable && pwrite && hit;

    // Purpose: pick the read source for the addressed word.
    always_comb begin
        rd_sel = RD_ZERO;
        if (hit) begin
            case (idx)
                IDX_MODE:   rd_sel = RD_MODE;
                IDX_ENSTAT: rd_sel = RD_ENSTAT;
                IDX_STAT:   rd_sel = RD_STAT;
                IDX_MASK:   rd_sel = RD_MASK;
                IDX_DATA:   rd_sel = RD_DATA;
                default:    rd_sel = RD_ZERO;
            endcase
        end
    end

    // Purpose: raise the write strobe of the addressed register.
    always_comb begin
        wr      = '0;
        wr.ctrl = wr_acc && (idx == IDX_CTRL);
        wr.mode = wr_acc && (idx == IDX_MODE);
        wr.en   = wr_acc && (idx == IDX_EN);
        wr.dis  = wr_acc && (idx == IDX_DIS);
        wr.ie   = wr_acc && (idx == IDX_IE);
        wr.id   = wr_acc && (idx == IDX_ID);
        wr.data = wr_acc && (idx == IDX_DATA);
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr)) else $error("more than one write strobe"); // R9
    AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite) |-> (wr == '0)) else $error("strobe on read"); // R7
endmodule

// File: rtl/periph_setclr_bits.sv
// Bit vector changed only by write-one-to-set and write-one-to-clear strobes.
// Assumes at most one strobe per cycle from the bus; if both arrive, clear wins.
module periph_setclr_bits #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q_o
);
    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;

    assign set_m = set_stb ? set_bits : '0;
    assign clr_m = clr_stb ? clr_bits : '0;

    // Purpose: apply set then clear, so clear has priority on a shared bit.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o | set_m) & ~clr_m;
    end

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((q_o & $past(clr_bits)) == '0)) else $error("clear lost"); // R4
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && !clr_stb) |=> ((q_o & $past(set_bits)) == $past(set_bits)))
        else $error("set lost"); // R5
    AST_ZEROS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> ((q_o & ~$past(set_bits | clr_bits)) == ($past(q_o) & ~$past(set_bits | clr_bits))))
        else $error("zero bit changed"); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(q_o)) else $error("bits drifted"); // R5
endmodule

// File: rtl/periph_irq_combine.sv
// Interrupt source: masked status reduced to one request line.
// Assumes stat_i is already synchronous to clk.
module periph_irq_combine #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    // Purpose: request an interrupt while any enabled status bit is high.
    always_comb irq_o = |(stat_i & mask_i);

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> !irq_o) else $error("irq with empty mask"); // R6
    AST_IRQ_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_i == '0) |-> !irq_o) else $error("irq with no status"); // R6
endmodule

// File: rtl/periph_regbank.sv
// Top of the peripheral register bank: zero-wait APB slave with a command
// register, a mode and a data word, set/clear channel enables and mask, a
// status view and the interrupt request. Assumes word-only accesses.
module periph_regbank
    import periph_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CMD_W  = 8,
    parameter int unsigned MODE_W = 16,
    parameter int unsigned CH_W   = 8,
    parameter int unsigned STAT_W = 8
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]  pwdata,
    output logic [BUS_W-1:0]  prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [STAT_W-1:0] stat_i,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [CH_W-1:0]   chan_en_o,
    output logic [BUS_W-1:0]  data_o,
    output logic              irq_o
);
    wr_strobe_t          wr;
    rd_sel_t             rd_sel;
    logic [STAT_W-1:0]   mask_q;
    logic [CMD_W-1:0]    cmd_q;
    logic [MODE_W-1:0]   mode_q;
    logic [BUS_W-1:0]    data_q;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    periph_apb_decode #(.ADDR_W(ADDR_W)) i_decode (
        .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .wr(wr), .rd_sel(rd_sel)
    );

    periph_setclr_bits #(.W(CH_W)) i_chan (
        .clk(pclk), .rst_n(presetn), .set_stb(wr.en), .clr_stb(wr.dis),
        .set_bits(pwdata[CH_W-1:0]), .clr_bits(pwdata[CH_W-1:0]), .q_o(chan_en_o)
    );

    periph_setclr_bits #(.W(STAT_W)) i_mask (
        .clk(pclk), .rst_n(presetn), .set_stb(wr.ie), .clr_stb(wr.id),
        .set_bits(pwdata[STAT_W-1:0]), .clr_bits(pwdata[STAT_W-1:0]), .q_o(mask_q)
    );

    periph_irq_combine #(.W(STAT_W)) i_irq (
        .clk(pclk), .rst_n(presetn), .stat_i(stat_i), .mask_i(mask_q), .irq_o(irq_o)
    );

    // Purpose: turn a command write into a one-cycle pulse.
    always_ff @(posedge pclk) begin
        if (!presetn)     cmd_q <= '0;
        else if (wr.ctrl) cmd_q <= pwdata[CMD_W-1:0];
        else              cmd_q <= '0;
    end

    // Purpose: hold the mode and data words written by software.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            mode_q <= '0;
            data_q <= '0;
        end else begin
            if (wr.mode) mode_q <= pwdata[MODE_W-1:0];
            if (wr.data) data_q <= pwdata;
        end
    end

    // Purpose: zero-extended read mux for the addressed register.
    always_comb begin
        case (rd_sel)
            RD_MODE:   prdata = BUS_W'(mode_q);
            RD_ENSTAT: prdata = BUS_W'(chan_en_o);
            RD_STAT:   prdata = BUS_W'(stat_i);
            RD_MASK:   prdata = BUS_W'(mask_q);
            RD_DATA:   prdata = data_q;
            default:   prdata = '0;
        endcase
    end

    assign cmd_o  = cmd_q;
    assign mode_o = mode_q;
    assign data_o = data_q;

    AST_CMD_SINGLE: assert property (@(posedge pclk) disable iff (!presetn)
        !wr.ctrl |=> (cmd_o == '0)) else $error("command pulse too long"); // R2
    AST_MODE_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
        !wr.mode |=> $stable(mode_o)) else $error("mode changed"); // R3
    AST_DATA_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
        !wr.data |=> $stable(data_o)) else $error("data changed"); // R8
    AST_BUS_OK: assert property (@(posedge pclk) disable iff (!presetn)
        psel |-> (pready && !pslverr)) else $error("bus response"); // R10
endmodule

// File: tb/test_periph_regbank.sv
`timescale 1ns/1ps
module test_periph_regbank;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [7:0]  stat = '0;
    logic [7:0]  cmd_o;
    logic [15:0] mode_o;
    logic [7:0]  chan_en_o;
    logic [31:0] data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_mode = '0;
    logic [7:0]  m_en = '0, m_mask = '0, m_cmd = '0;
    logic [31:0] m_data = '0;
    logic [7:0]  cmd_s1, cmd_s2;
    logic [31:0] rd;

    always #2 pclk = ~pclk;

    periph_regbank i_periph_regbank (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .stat_i(stat), .cmd_o(cmd_o),
        .mode_o(mode_o), .chan_en_o(chan_en_o), .data_o(data_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        if (a[11:6] != 0) return 32'h0;
        case (a[5:2])
            4'd1:  return {16'h0, m_mode};
            4'd6:  return {24'h0, m_en};
            4'd8:  return {24'h0, stat};
            4'd11: return {24'h0, m_mask};
            4'd12: return m_data;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        if (a[11:6] != 0) return "R9";
        case (a[5:2])
            4'd0:  return "R2";
            4'd1:  return "R3";
            4'd6:  return "R4";
            4'd8:  return "R7";
            4'd11: return "R5";
            4'd12: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        m_cmd = 8'h0;
        if (a[11:6] == 0) begin
            case (a[5:2])
                4'd0:  m_cmd = d[7:0];
                4'd1:  m_mode = d[15:0];
                4'd4:  m_en = m_en | d[7:0];
                4'd5:  m_en = m_en & ~d[7:0];
                4'd9:  m_mask = m_mask | d[7:0];
                4'd10: m_mask = m_mask & ~d[7:0];
                4'd12: m_data = d;
                default: ;
            endcase
        end
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        cmd_s1 = cmd_o;
        @(negedge pclk);
        cmd_s2 = cmd_o;
        model_write(a, d);
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1 d = prdata;
        check("R10", {30'h0, pready, pslverr}, 32'h2);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic check_outputs(input string tag);
        check(tag, {16'h0, mode_o}, {16'h0, m_mode});
        check(tag, {24'h0, chan_en_o}, {24'h0, m_en});
        check(tag, data_o, m_data);
        check("R6", {31'h0, irq_o}, {31'h0, |(stat & m_mask)});
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] a;
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);

        // Reset state (R3 R4 R5 R8 R2 R10)
        check("R3", {16'h0, mode_o}, 32'h0);
        check("R4", {24'h0, chan_en_o}, 32'h0);
        check("R8", data_o, 32'h0);
        check("R2", {24'h0, cmd_o}, 32'h0);
        check("R10", {30'h0, pready, pslverr}, 32'h2);
        apb_read(12'h02C, rd); check("R5", rd, 32'h0);

        // R2: command pulse lasts one cycle, read returns zero
        apb_write(12'h000, 32'hFFFF_FFA5);
        check("R2", {24'h0, cmd_s1}, 32'hA5);
        check("R2", {24'h0, cmd_s2}, 32'h0);
        apb_read(12'h000, rd); check("R2", rd, 32'h0);

        // R3 and R9: upper bits of mode read zero
        apb_write(12'h004, 32'hDEAD_BEEF);
        apb_read(12'h004, rd); check("R3", rd, 32'h0000_BEEF);
        check("R9", {16'h0, mode_o}, 32'h0000_BEEF);

        // R4: set then clear with mixed bits, zeros keep state
        apb_write(12'h010, 32'h0000_00F0);
        apb_write(12'h010, 32'h0000_0003);
        apb_read(12'h018, rd); check("R4", rd, 32'h0000_00F3);
        apb_write(12'h014, 32'h0000_0021);
        apb_read(12'h018, rd); check("R4", rd, 32'h0000_00D2);
        check("R4", {24'h0, chan_en_o}, 32'hD2);

        // R1: low address bits ignored
        apb_write(12'h027, 32'h0000_0081);
        apb_read(12'h02D, rd); check("R1", rd, 32'h0000_0081);

        // R6: irq follows masked status in the same cycle
        @(negedge pclk); stat = 8'h01; #1;
        check("R6", {31'h0, irq_o}, 32'h1);
        stat = 8'h7E; #1;
        check("R6", {31'h0, irq_o}, 32'h0);
        apb_write(12'h028, 32'h0000_0001);
        stat = 8'h81; #1;
        check("R6", {31'h0, irq_o}, 32'h1);

        // R7: status read and write ignored
        apb_write(12'h020, 32'hFFFF_FFFF);
        apb_read(12'h020, rd); check("R7", rd, 32'h0000_0081);
        apb_read(12'h02C, rd); check("R7", rd, 32'h0000_0080);

        // R8: data full width
        apb_write(12'h030, 32'h1234_5678);
        apb_read(12'h030, rd); check("R8", rd, 32'h1234_5678);

        // R9: unmapped write ignored, unmapped reads zero
        apb_write(12'h070, 32'hFFFF_FFFF);
        apb_write(12'h0D0, 32'hFFFF_FFFF);
        check_outputs("R9");
        apb_read(12'h03C, rd); check("R9", rd, 32'h0);
        apb_read(12'h0F0, rd); check("R9", rd, 32'h0);

        // Random mix against the model
        for (int i = 0; i < 400; i++) begin
            a = {($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'h0,
                 4'($urandom), 2'($urandom)};
            d = $urandom;
            case ($urandom_range(0, 2))
                0: begin
                    apb_write(a, d);
                    check("R2", {24'h0, cmd_s1}, {24'h0, m_cmd});
                    check("R2", {24'h0, cmd_s2}, 32'h0);
                    check_outputs(tag_of(a));
                end
                1: begin
                    apb_read(a, rd);
                    check(tag_of(a), rd, exp_read(a));
                end
                default: begin
                    @(negedge pclk); stat = 8'($urandom); #1;
                    check("R6", {31'h0, irq_o}, {31'h0, |(stat & m_mask)});
                end
            endcase
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule